// File: doc/BRIEF.md
# Run-Time Sized SPI Data Queues

This block holds the two word queues that sit between software and the serial shifter of an SPI master. Software writes transmit words into one queue, and the shifter takes them out one at a time. The shifter writes each received word into the other queue, and software reads it back. Each queue has 32 physical slots of 32 bits. The usable depth is chosen at run time: a compact mode always uses four slots, and an extended mode picks 32, 16 or 8 slots from the programmed frame length. Narrow frames get more buffering, and wide frames get less.

Each queue reports empty, full and one-short-of-full levels. The read side of each queue presents its oldest word without waiting for a read request. A word that the shifter delivers while the receive queue is full is discarded. That event sets a status bit, which the next software read clears. It also sets a separate interrupt bit, which stays set until it is acknowledged. A clear input flushes both queues at once. The register decoding and the serial shifting belong to neighbouring blocks.

Top module: `spi_adaptive_fifos`

## Requirements
- R1: In the cycle after `rst` is high, both queues are empty, no full or almost-full flag is set, and `rx_overrun_o` and `rx_overrun_irq_o` are 0.
- R2: With `wide_mode_i` = 0, each queue accepts exactly 4 words, whatever `frame_len_i` holds.
- R3: With `wide_mode_i` = 1, the depth is 32 words when `frame_len_i` is 8 or less, 16 words when it is 9 to 16, and 8 words when it is 17 or more.
- R4: A transmit write while the transmit occupancy is at or above the depth is ignored: the occupancy and the stored words stay unchanged.
- R5: A queue's empty flag is 1 exactly when it holds no word. Its almost-full flag is 1 exactly when it holds depth-1 words. Its full flag is 1 exactly when it holds depth words or more.
- R6: A receive write while the receive queue is full stores nothing, and in the next cycle both `rx_overrun_o` and `rx_overrun_irq_o` are 1.
- R7: An accepted receive read (with the queue not empty) clears `rx_overrun_o` in the next cycle, unless a word is dropped in the same cycle. `rx_overrun_irq_o` stays 1 until `rx_overrun_ack_i` is pulsed.
- R8: A cycle with `fifo_clear_i` high empties both queues and clears both overrun bits.
- R9: Words leave each queue in the order they were written. The read data output shows the oldest stored word, and a read of an empty queue is ignored.
- R10: A change of depth while words are stored keeps every stored word. Only the full and almost-full comparisons use the new depth.
- R11: A write and a read in the same cycle, with the occupancy above 0 and below the depth, leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clear_i | input | 1 | Flush both queues and the overrun bits |
| wide_mode_i | input | 1 | 1 selects the depth from the frame length; 0 selects 4 |
| frame_len_i | input | 6 | Frame length in bits |
| tx_wr_i | input | 1 | Software writes a transmit word |
| tx_wdata_i | input | 32 | Transmit word to store |
| tx_rd_i | input | 1 | Shifter takes the oldest transmit word |
| tx_rdata_o | output | 32 | Oldest transmit word |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue at or above depth |
| tx_almost_full_o | output | 1 | Transmit queue at depth-1 |
| rx_wr_i | input | 1 | Shifter delivers a received word |
| rx_wdata_i | input | 32 | Received word |
| rx_rd_i | input | 1 | Software takes the oldest received word |
| rx_rdata_o | output | 32 | Oldest received word |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue at or above depth |
| rx_almost_full_o | output | 1 | Receive queue at depth-1 |
| rx_overrun_o | output | 1 | A received word was dropped since the last read |
| rx_overrun_irq_o | output | 1 | Interrupt bit for a dropped word, held until acknowledged |
| rx_overrun_ack_i | input | 1 | Clears `rx_overrun_irq_o` |

## Verification
The assertions assume that the minimum depth is four. Under that assumption, empty, almost-full and full can never be set together, and the stimulus only ever selects depths of 4, 8, 16 and 32. The occupancy checks assume that `fifo_clear_i` is low in the checked cycle, so every such test drives a clear only in a cycle of its own. The configuration inputs are only changed between operations, so each write or read sees one settled depth.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int WORD_W     = 32;
    localparam int PHYS_DEPTH = 32;
    localparam int PTR_W      = $clog2(PHYS_DEPTH);
    localparam int CNT_W      = PTR_W + 1;
    localparam int FLEN_W     = 6;
    localparam int COMPACT_DEPTH = 4;
    localparam int NARROW_LIMIT  = 8;
    localparam int MEDIUM_LIMIT  = 16;

    typedef struct packed {
        logic empty;
        logic almost_full;
        logic full;
    } level_flags_t;

    // Usable depth from the mode bit and the frame length in bits.
    function automatic logic [CNT_W-1:0] usable_depth(
        input logic              wide,
        input logic [FLEN_W-1:0] flen
    );
        if (!wide)
            return CNT_W'(COMPACT_DEPTH);
        else if (flen <= FLEN_W'(NARROW_LIMIT))
            return CNT_W'(PHYS_DEPTH);
        else if (flen <= FLEN_W'(MEDIUM_LIMIT))
            return CNT_W'(PHYS_DEPTH / 2);
        else
            return CNT_W'(PHYS_DEPTH / 4);
    endfunction

endpackage

// File: rtl/spi_fifo_depth_sel.sv
module spi_fifo_depth_sel
    import spi_fifo_pkg::*;
(
    input  logic              wide_i,
    input  logic [FLEN_W-1:0] flen_i,
    output logic [CNT_W-1:0]  depth_o
);
    always_comb depth_o = usable_depth(wide_i, flen_i);
endmodule

// File: rtl/spi_fifo_core.sv
module spi_fifo_core
    import spi_fifo_pkg::*;
#(
    parameter int WIDTH   = WORD_W,
    parameter int ENTRIES = PHYS_DEPTH,
    localparam int AW     = $clog2(ENTRIES),
    localparam int CW     = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [CW-1:0]    depth_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [CW-1:0]    count_o,
    output level_flags_t     flags_o,
    output logic             rd_ok_o,
    output logic             drop_o
);
    logic [WIDTH-1:0] slots [ENTRIES];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count, count_nx;
    logic             at_limit, wr_ok, rd_ok;

    // The full test is at-or-above, so a shrunk depth cannot admit words.
    assign at_limit = (count >= depth_i);
    assign wr_ok    = wr_i && !at_limit;
    assign rd_ok    = rd_i && (count != '0);

    always_comb begin
        count_nx = count;
        unique case ({wr_ok, rd_ok})
            2'b10:   count_nx = count + CW'(1);
            2'b01:   count_nx = count - CW'(1);
            default: count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
            count <= count_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) slots[wr_ptr] <= wdata_i;
    end

    assign rdata_o             = slots[rd_ptr];
    assign count_o             = count;
    assign flags_o.empty       = (count == '0);
    assign flags_o.almost_full = (count == depth_i - CW'(1));
    assign flags_o.full        = at_limit;
    assign rd_ok_o             = rd_ok;
    assign drop_o              = wr_i && at_limit;
endmodule

// File: rtl/spi_adaptive_fifos.sv
module spi_adaptive_fifos
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W  = WORD_W,
    parameter int SLOTS   = PHYS_DEPTH,
    parameter int LEN_W   = FLEN_W,
    localparam int CW     = $clog2(SLOTS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_clear_i,
    input  logic              wide_mode_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_wdata_i,
    input  logic              tx_rd_i,
    output logic [DATA_W-1:0] tx_rdata_o,
    output logic              tx_empty_o,
    output logic              tx_full_o,
    output logic              tx_almost_full_o,
    input  logic              rx_wr_i,
    input  logic [DATA_W-1:0] rx_wdata_i,
    input  logic              rx_rd_i,
    output logic [DATA_W-1:0] rx_rdata_o,
    output logic              rx_empty_o,
    output logic              rx_full_o,
    output logic              rx_almost_full_o,
    output logic              rx_overrun_o,
    output logic              rx_overrun_irq_o,
    input  logic              rx_overrun_ack_i
);
    logic [CW-1:0] depth;
    logic [CW-1:0] tx_count, rx_count;
    level_flags_t  tx_flags, rx_flags;
    logic          tx_rd_ok, tx_drop, rx_rd_ok, rx_drop;
    logic          overrun_q, overrun_irq_q;

    spi_fifo_depth_sel u_depth (
        .wide_i  (wide_mode_i),
        .flen_i  (frame_len_i),
        .depth_o (depth)
    );

    spi_fifo_core #(.WIDTH(DATA_W), .ENTRIES(SLOTS)) u_txq (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (fifo_clear_i),
        .depth_i (depth),
        .wr_i    (tx_wr_i),
        .wdata_i (tx_wdata_i),
        .rd_i    (tx_rd_i),
        .rdata_o (tx_rdata_o),
        .count_o (tx_count),
        .flags_o (tx_flags),
        .rd_ok_o (tx_rd_ok),
        .drop_o  (tx_drop)
    );

    spi_fifo_core #(.WIDTH(DATA_W), .ENTRIES(SLOTS)) u_rxq (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (fifo_clear_i),
        .depth_i (depth),
        .wr_i    (rx_wr_i),
        .wdata_i (rx_wdata_i),
        .rd_i    (rx_rd_i),
        .rdata_o (rx_rdata_o),
        .count_o (rx_count),
        .flags_o (rx_flags),
        .rd_ok_o (rx_rd_ok),
        .drop_o  (rx_drop)
    );

    // A dropped receive word wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (rst || fifo_clear_i) begin
            overrun_q     <= 1'b0;
            overrun_irq_q <= 1'b0;
        end else begin
            if (rx_drop)       overrun_q <= 1'b1;
            else if (rx_rd_ok) overrun_q <= 1'b0;
            if (rx_drop)               overrun_irq_q <= 1'b1;
            else if (rx_overrun_ack_i) overrun_irq_q <= 1'b0;
        end
    end

    assign tx_empty_o       = tx_flags.empty;
    assign tx_full_o        = tx_flags.full;
    assign tx_almost_full_o = tx_flags.almost_full;
    assign rx_empty_o       = rx_flags.empty;
    assign rx_full_o        = rx_flags.full;
    assign rx_almost_full_o = rx_flags.almost_full;
    assign rx_overrun_o     = overrun_q;
    assign rx_overrun_irq_o = overrun_irq_q;

    logic unused_tx;
    assign unused_tx = tx_rd_ok ^ tx_drop;
endmodule

// File: rtl/spi_fifo_checker.sv
module spi_fifo_checker #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_clear_i,
    input logic          tx_wr_i,
    input logic          tx_rd_i,
    input logic          tx_empty_o,
    input logic          tx_full_o,
    input logic          tx_almost_full_o,
    input logic          rx_wr_i,
    input logic          rx_rd_i,
    input logic          rx_empty_o,
    input logic          rx_full_o,
    input logic          rx_almost_full_o,
    input logic          rx_overrun_o,
    input logic          rx_overrun_irq_o,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx_empty_o && rx_empty_o && !tx_full_o && !rx_full_o &&
                 !rx_overrun_o && !rx_overrun_irq_o));

    a_r4_tx_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (!fifo_clear_i && tx_full_o && tx_wr_i && !tx_rd_i)
        |=> (tx_count == $past(tx_count)));

    a_r5_tx_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({tx_empty_o, tx_almost_full_o, tx_full_o}) <= 1);

    a_r5_rx_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({rx_empty_o, rx_almost_full_o, rx_full_o}) <= 1);

    a_r6_drop_sets_overrun: assert property (@(posedge clk) disable iff (rst)
        (!fifo_clear_i && rx_full_o && rx_wr_i)
        |=> (rx_overrun_o && rx_overrun_irq_o));

    a_r7_read_clears_overrun: assert property (@(posedge clk) disable iff (rst)
        (!fifo_clear_i && rx_rd_i && !rx_empty_o && !(rx_wr_i && rx_full_o))
        |=> !rx_overrun_o);

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
        fifo_clear_i |=> (tx_empty_o && rx_empty_o && !rx_overrun_o &&
                          !rx_overrun_irq_o));

    a_r11_tx_wr_rd_balance: assert property (@(posedge clk) disable iff (rst)
        (!fifo_clear_i && tx_wr_i && tx_rd_i && !tx_empty_o && !tx_full_o)
        |=> $stable(tx_count));

    a_r11_rx_wr_rd_balance: assert property (@(posedge clk) disable iff (rst)
        (!fifo_clear_i && rx_wr_i && rx_rd_i && !rx_empty_o && !rx_full_o)
        |=> $stable(rx_count));
endmodule

bind spi_adaptive_fifos spi_fifo_checker #(.CW(CW)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .fifo_clear_i     (fifo_clear_i),
    .tx_wr_i          (tx_wr_i),
    .tx_rd_i          (tx_rd_i),
    .tx_empty_o       (tx_empty_o),
    .tx_full_o        (tx_full_o),
    .tx_almost_full_o (tx_almost_full_o),
    .rx_wr_i          (rx_wr_i),
    .rx_rd_i          (rx_rd_i),
    .rx_empty_o       (rx_empty_o),
    .rx_full_o        (rx_full_o),
    .rx_almost_full_o (rx_almost_full_o),
    .rx_overrun_o     (rx_overrun_o),
    .rx_overrun_irq_o (rx_overrun_irq_o),
    .tx_count         (tx_count),
    .rx_count         (rx_count)
);

// File: tb/spi_adaptive_fifos_test.sv
module spi_adaptive_fifos_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       wide;
        logic [5:0] flen;
        logic [5:0] depth;
    } cfg_vec_t;

    // R2/R3: mode, frame length, expected usable depth
    localparam cfg_vec_t CFG_TABLE [8] = '{
        '{1'b0, 6'd8,  6'd4},
        '{1'b0, 6'd32, 6'd4},
        '{1'b1, 6'd1,  6'd32},
        '{1'b1, 6'd8,  6'd32},
        '{1'b1, 6'd9,  6'd16},
        '{1'b1, 6'd16, 6'd16},
        '{1'b1, 6'd17, 6'd8},
        '{1'b1, 6'd32, 6'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_clear_i = 1'b0;
    logic        wide_mode_i = 1'b0;
    logic [5:0]  frame_len_i = 6'd8;
    logic        tx_wr_i = 1'b0, tx_rd_i = 1'b0;
    logic [31:0] tx_wdata_i = '0;
    logic [31:0] tx_rdata_o;
    logic        tx_empty_o, tx_full_o, tx_almost_full_o;
    logic        rx_wr_i = 1'b0, rx_rd_i = 1'b0;
    logic [31:0] rx_wdata_i = '0;
    logic [31:0] rx_rdata_o;
    logic        rx_empty_o, rx_full_o, rx_almost_full_o;
    logic        rx_overrun_o, rx_overrun_irq_o;
    logic        rx_overrun_ack_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_adaptive_fifos uut (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_clear();
        fifo_clear_i = 1'b1;
        tick();
        fifo_clear_i = 1'b0;
    endtask

    task automatic tx_write(input logic [31:0] d);
        tx_wr_i = 1'b1; tx_wdata_i = d;
        tick();
        tx_wr_i = 1'b0;
    endtask

    task automatic rx_write(input logic [31:0] d);
        rx_wr_i = 1'b1; rx_wdata_i = d;
        tick();
        rx_wr_i = 1'b0;
    endtask

    task automatic tx_read();
        tx_rd_i = 1'b1; tick(); tx_rd_i = 1'b0;
    endtask

    task automatic rx_read();
        rx_rd_i = 1'b1; tick(); rx_rd_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog expired: actual hung expected finished");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "tx empty", 32'(tx_empty_o), 32'd1);
        check("R1", "rx empty", 32'(rx_empty_o), 32'd1);
        check("R1", "flags", 32'({tx_full_o, tx_almost_full_o, rx_full_o, rx_almost_full_o}), 32'd0);
        check("R1", "overrun", 32'({rx_overrun_o, rx_overrun_irq_o}), 32'd0);

        // R2 R3 R4 R5 R9: fill past the depth, then drain in order
        foreach (CFG_TABLE[k]) begin
            automatic int dep = int'(CFG_TABLE[k].depth);
            automatic int n = 0;
            automatic bit order_ok = 1'b1;
            automatic logic [31:0] base = 32'h1000_0000 * (k + 1);
            wide_mode_i = CFG_TABLE[k].wide;
            frame_len_i = CFG_TABLE[k].flen;
            do_clear();
            for (int i = 0; i < dep + 2; i++) begin
                tx_write(base + 32'(i));
                if (i == dep - 2)
                    check("R5", "almost full at depth-1", 32'({tx_almost_full_o, tx_full_o}), 32'b10);
            end
            check("R5", "full at depth", 32'({tx_almost_full_o, tx_full_o}), 32'b01);
            while (!tx_empty_o && n < 40) begin
                if (tx_rdata_o !== base + 32'(n)) order_ok = 1'b0;
                tx_read();
                n++;
            end
            check("R3", "words accepted", 32'(n), 32'(dep));
            check("R9", "drain order", 32'(order_ok), 32'd1);
        end

        // R6 R7: receive overrun in compact mode (depth 4)
        wide_mode_i = 1'b0;
        do_clear();
        for (int i = 0; i < 5; i++) rx_write(32'hA000_0000 + 32'(i));
        check("R6", "rx full", 32'(rx_full_o), 32'd1);
        check("R6", "overrun bits", 32'({rx_overrun_o, rx_overrun_irq_o}), 32'b11);
        rx_read();
        check("R7", "overrun after read", 32'({rx_overrun_o, rx_overrun_irq_o}), 32'b01);
        check("R9", "rx second word", rx_rdata_o, 32'hA000_0001);
        rx_read(); rx_read();
        check("R6", "last stored word", rx_rdata_o, 32'hA000_0003);
        rx_read();
        check("R6", "dropped word absent", 32'(rx_empty_o), 32'd1);
        rx_overrun_ack_i = 1'b1; tick(); rx_overrun_ack_i = 1'b0;
        check("R7", "irq after ack", 32'(rx_overrun_irq_o), 32'd0);

        // R9: read of an empty queue is ignored
        rx_read();
        rx_write(32'h5555_0001);
        check("R9", "word after empty read", rx_rdata_o, 32'h5555_0001);
        rx_read();
        check("R9", "empty again", 32'(rx_empty_o), 32'd1);

        // R10: shrink depth with words stored
        wide_mode_i = 1'b1; frame_len_i = 6'd8;
        do_clear();
        for (int i = 0; i < 10; i++) tx_write(32'hB000_0000 + 32'(i));
        check("R10", "not full at depth 32", 32'(tx_full_o), 32'd0);
        frame_len_i = 6'd20;
        @(negedge clk);
        check("R10", "full after shrink", 32'({tx_almost_full_o, tx_full_o}), 32'b01);
        tx_write(32'hDEAD_BEEF);
        begin
            automatic int n = 0;
            automatic bit ok = 1'b1;
            while (!tx_empty_o && n < 40) begin
                if (tx_rdata_o !== 32'hB000_0000 + 32'(n)) ok = 1'b0;
                tx_read();
                n++;
            end
            check("R10", "words kept", 32'(n), 32'd10);
            check("R4", "write at shrunk depth ignored", 32'(ok), 32'd1);
        end

        // R11: write and read together
        wide_mode_i = 1'b0;
        do_clear();
        tx_write(32'hC000_0000); tx_write(32'hC000_0001);
        for (int i = 2; i < 5; i++) begin
            tx_wr_i = 1'b1; tx_rd_i = 1'b1; tx_wdata_i = 32'hC000_0000 + 32'(i);
            tick();
        end
        tx_wr_i = 1'b0; tx_rd_i = 1'b0;
        check("R11", "head after balanced cycles", tx_rdata_o, 32'hC000_0003);
        tx_read();
        check("R11", "second word", tx_rdata_o, 32'hC000_0004);
        tx_read();
        check("R11", "occupancy kept at two", 32'(tx_empty_o), 32'd1);

        // R8: clear both queues and overrun bits
        for (int i = 0; i < 3; i++) tx_write(32'(i));
        for (int i = 0; i < 5; i++) rx_write(32'(i));
        do_clear();
        check("R8", "both empty", 32'({tx_empty_o, rx_empty_o}), 32'b11);
        check("R8", "overrun cleared", 32'({rx_overrun_o, rx_overrun_irq_o}), 32'b00);
        check("R8", "full cleared", 32'({tx_full_o, rx_full_o}), 32'b00);

        finish_run();
    end
endmodule